// File: doc/BRIEF.md
# Supply Low-Voltage Detector Controller

This block is the digital side of a supply monitor. An analog divider and comparator, outside the block, tell it whether the supply has dropped below a selectable threshold. The block switches the analog path on and keeps it on. It waits out a settling time and then watches the comparator. It reports a low supply in two ways: through a live status bit that software can poll, and through an interrupt with its own flag and mask.

Analog power and detection are kept apart. Once software enables the monitor, the analog path stays powered even if software clears the enable again. Only a reset or the stop-mode input removes power. Because of this, a later re-enable detects at once and does not wait again for settling. Changing the threshold while powered restarts the settling wait, since the comparator output is not trustworthy right after the change.

The register port is a single-cycle write strobe with an address. Reads are combinational. Address 0 is the control register: bit 7 is the enable and bit 0 is the status. Address 1 holds the threshold code. Address 2 holds the interrupt bits: bit 0 is the flag and bit 1 is the mask. Address 3 reads as zero.

Top module: `lvd_ctrl`

## Requirements
- R1: After reset, `ana_pwr` and `irq` are 0. Address 0 reads 0x00, address 1 reads 0x00 and address 2 reads 0x02 (flag 0, mask 1).
- R2: A write to address 0 with bit 7 set raises `ana_pwr` at that clock edge, unless `stop_mode` is high at that edge.
- R3: `ana_pwr` stays 1 when the enable bit is written to 0. It drops at the edge where `stop_mode` is high, and it stays 0 until enable is written to 1 again. `stop_mode` wins over a simultaneous enable write.
- R4: For SETTLE_CYC edges after power comes on, starting with the write edge, status bit 0 at address 0 reads 0 and the flag cannot be set. The count is SETTLE_CYC = CLK_KHZ*SETTLE_US/1000 cycles, at least 1.
- R5: Once settled, status bit 0 equals `cmp_low` delayed by two clock edges through a two-flop synchronizer. The status does not depend on the enable bit.
- R6: The flag (bit 0 at address 2) is set one edge after the gated indication rises. The gated indication is the synchronized low AND settled AND enabled. The flag then holds until software writes 0 to bit 0. Writing 1 there has no effect, and a set in the same cycle wins over a clear.
- R7: `irq` is 1 exactly when the flag is 1 and the mask (bit 1 at address 2) is 0.
- R8: While the enable is 0, a low supply never sets the flag. Re-enabling while still powered, with the supply low, sets the flag one edge after the write, with no settling wait.
- R9: `lvl_sel` follows address 1 bits [LVL_W-1:0] from the write edge onward. A write to address 1 while powered restarts the settling wait of R4.
- R10: Address 3 reads 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| stop_mode | input | 1 | Stop-mode request; removes analog power |
| cmp_low | input | 1 | Asynchronous comparator output, 1 = supply below threshold |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr`, combinational |
| ana_pwr | output | 1 | Power enable for the analog divider and comparator |
| lvl_sel | output | LVL_W | Threshold code for the analog divider |
| irq | output | 1 | Interrupt request (flag and not mask) |

## Verification
A register write takes effect at its own edge. The bench therefore samples `ana_pwr`, `lvl_sel` and register reads half a cycle after that edge. A change on `cmp_low` reaches the status bit after exactly two edges, and reaches the flag and `irq` after three. Settling completes SETTLE_CYC edges after the enabling write, so the bench checks both the last cycle before that point and the first cycle at it. Every check waits a counted number of falling edges from the stimulus and then reads the outputs, so each one lands on the exact cycle its result is due.

// File: rtl/lvd_pkg.sv
package lvd_pkg;
    localparam logic [1:0] A_CTRL = 2'd0;
    localparam logic [1:0] A_LVL  = 2'd1;
    localparam logic [1:0] A_IRQ  = 2'd2;
    localparam int B_EN   = 7;
    localparam int B_STAT = 0;
    localparam int B_FLAG = 0;
    localparam int B_MASK = 1;
endpackage

// File: rtl/lvd_sync.sv
module lvd_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_in,
    output logic q_out
);
    logic [STAGES-1:0] sh_d, sh_q;

    generate
        if (STAGES == 1) begin : g_one
            always_comb sh_d = d_in;
        end else begin : g_many
            always_comb sh_d = {sh_q[STAGES-2:0], d_in};
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign q_out = sh_q[STAGES-1];
endmodule

// File: rtl/lvd_settle.sv
module lvd_settle #(
    parameter int CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic powered,
    output logic done
);
    localparam int CW = $clog2(CYC + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (restart)            cnt_d = CW'(CYC);
        else if (cnt_q != '0)   cnt_d = cnt_q - CW'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign done = powered && (cnt_q == '0);
endmodule

// File: rtl/lvd_ctrl.sv
module lvd_ctrl #(
    parameter int CLK_KHZ   = 250000,
    parameter int SETTLE_US = 2000,
    parameter int LVL_W     = 3,
    parameter int SYNC_N    = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             stop_mode,
    input  logic             cmp_low,
    input  logic             wr_en,
    input  logic [1:0]       addr,
    input  logic [7:0]       wdata,
    output logic [7:0]       rdata,
    output logic             ana_pwr,
    output logic [LVL_W-1:0] lvl_sel,
    output logic             irq
);
    import lvd_pkg::*;

    localparam int RAW_CYC    = (CLK_KHZ * SETTLE_US) / 1000;
    localparam int SETTLE_CYC = (RAW_CYC < 1) ? 1 : RAW_CYC;

    typedef struct packed {
        logic             en;
        logic             pwr;
        logic [LVL_W-1:0] lvl;
        logic             flag;
        logic             mask;
        logic             prev;
    } st_t;

    st_t st_d, st_q;

    logic low_s, done, restart, live, flag_now, mask_now;
    logic wr_ctrl, wr_lvl, wr_irq;
    logic unused_wbits;

    assign unused_wbits = ^wdata;

    lvd_sync #(.STAGES(SYNC_N)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_in(cmp_low), .q_out(low_s)
    );

    lvd_settle #(.CYC(SETTLE_CYC)) u_settle (
        .clk(clk), .rst_n(rst_n), .restart(restart),
        .powered(st_q.pwr), .done(done)
    );

    assign wr_ctrl = wr_en && (addr == A_CTRL);
    assign wr_lvl  = wr_en && (addr == A_LVL);
    assign wr_irq  = wr_en && (addr == A_IRQ);

    // detection gated by enable, independent of analog power
    assign live = low_s && done && st_q.en;

    always_comb begin
        st_d = st_q;
        if (wr_ctrl)                   st_d.en  = wdata[B_EN];
        if (stop_mode)                 st_d.pwr = 1'b0;
        else if (wr_ctrl && wdata[B_EN]) st_d.pwr = 1'b1;
        if (wr_lvl)                    st_d.lvl = wdata[LVL_W-1:0];
        if (wr_irq) begin
            st_d.mask = wdata[B_MASK];
            if (!wdata[B_FLAG])        st_d.flag = 1'b0;
        end
        if (live && !st_q.prev)        st_d.flag = 1'b1;
        st_d.prev = live;
    end

    assign restart = (st_d.pwr && !st_q.pwr) ||
                     (wr_lvl && st_q.pwr && st_d.pwr);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.mask <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign flag_now = st_q.flag;
    assign mask_now = st_q.mask;

    always_comb begin
        rdata = 8'h00;
        case (addr)
            A_CTRL: begin
                rdata[B_EN]   = st_q.en;
                rdata[B_STAT] = low_s && done;
            end
            A_LVL:  rdata[LVL_W-1:0] = st_q.lvl;
            A_IRQ: begin
                rdata[B_FLAG] = flag_now;
                rdata[B_MASK] = mask_now;
            end
            default: rdata = 8'h00;
        endcase
    end

    assign ana_pwr = st_q.pwr;
    assign lvl_sel = st_q.lvl;
    assign irq     = flag_now && !mask_now;
endmodule

// File: rtl/lvd_ctrl_chk.sv
module lvd_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       stop_mode,
    input logic       wr_en,
    input logic [1:0] addr,
    input logic [7:0] wdata,
    input logic [7:0] rdata,
    input logic       ana_pwr,
    input logic       flag_now,
    input logic       done
);
    // R2
    pwr_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 2'd0 && wdata[7] && !stop_mode) |=> ana_pwr);

    // R3
    pwr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ana_pwr && !stop_mode) |=> ana_pwr);

    // R3
    stop_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_mode |=> !ana_pwr);

    // R4
    flag_settle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_now) |-> $past(done));

    // R4
    status_pwr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == 2'd0 && rdata[0]) |-> ana_pwr);

    // R6
    flag_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_now && !(wr_en && addr == 2'd2 && !wdata[0])) |=> flag_now);
endmodule

bind lvd_ctrl lvd_ctrl_chk u_chk (
    .clk(clk), .rst_n(rst_n), .stop_mode(stop_mode), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .ana_pwr(ana_pwr),
    .flag_now(flag_now), .done(done)
);

// File: tb/sim_lvd_ctrl.sv
module sim_lvd_ctrl;
    localparam int N = 20;   // 1000 kHz * 20 us / 1000

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       stop_mode = 1'b0;
    logic       cmp_low = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] addr = 2'd0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       ana_pwr;
    logic [2:0] lvl_sel;
    logic       irq;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    lvd_ctrl #(.CLK_KHZ(1000), .SETTLE_US(20), .LVL_W(3), .SYNC_N(2)) u0 (
        .clk(clk), .rst_n(rst_n), .stop_mode(stop_mode), .cmp_low(cmp_low),
        .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata),
        .ana_pwr(ana_pwr), .lvl_sel(lvl_sel), .irq(irq)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        addr = a;
        #0.5;
        d = rdata;
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [7:0] v;
        rd(2'd0, v); chk("R1 ctrl", v, 8'h00);
        rd(2'd1, v); chk("R1 lvl", v, 8'h00);
        rd(2'd2, v); chk("R1 irqreg", v, 8'h02);
        chk("R1 ana_pwr", {7'd0, ana_pwr}, 8'h00);
        chk("R1 irq", {7'd0, irq}, 8'h00);
        rd(2'd3, v); chk("R10 addr3", v, 8'h00);
    endtask

    task automatic t_power();
        logic [7:0] v;
        cmp_low = 1'b1;
        cyc(3);
        wr(2'd0, 8'h80);
        chk("R2 pwr on", {7'd0, ana_pwr}, 8'h01);
        rd(2'd0, v); chk("R4 status early", v, 8'h80);
        cyc(N - 1);
        rd(2'd0, v); chk("R4 status last unsettled", v, 8'h80);
        rd(2'd2, v); chk("R4 no flag unsettled", v, 8'h02);
        cyc(1);
        rd(2'd0, v); chk("R4 status settled", v, 8'h81);
        cyc(1);
        rd(2'd2, v); chk("R6 flag set", v, 8'h03);
        chk("R7 masked irq", {7'd0, irq}, 8'h00);
        wr(2'd2, 8'h00);
        rd(2'd2, v); chk("R6 flag cleared", v, 8'h00);
        wr(2'd2, 8'h01);
        cyc(2);
        rd(2'd2, v); chk("R6 write one no effect", v, 8'h00);
        chk("R7 no irq", {7'd0, irq}, 8'h00);
    endtask

    task automatic t_sync();
        logic [7:0] v;
        @(negedge clk); cmp_low = 1'b0;
        cyc(1);
        rd(2'd0, v); chk("R5 one edge", v, 8'h81);
        cyc(1);
        rd(2'd0, v); chk("R5 two edges", v, 8'h80);
        cmp_low = 1'b1;
        cyc(2);
        rd(2'd0, v); chk("R5 rise two edges", v, 8'h81);
        chk("R7 irq not yet", {7'd0, irq}, 8'h00);
        cyc(1);
        chk("R7 irq up", {7'd0, irq}, 8'h01);
        wr(2'd2, 8'h03);
        chk("R7 mask blocks", {7'd0, irq}, 8'h00);
        rd(2'd2, v); chk("R6 flag held", v, 8'h03);
        wr(2'd2, 8'h00);
    endtask

    task automatic t_disable();
        logic [7:0] v;
        wr(2'd0, 8'h00);
        chk("R3 pwr kept", {7'd0, ana_pwr}, 8'h01);
        rd(2'd0, v); chk("R5 status without enable", v, 8'h01);
        cmp_low = 1'b0; cyc(3);
        cmp_low = 1'b1; cyc(4);
        rd(2'd2, v); chk("R8 no flag disabled", v, 8'h00);
        wr(2'd0, 8'h80);
        rd(2'd2, v); chk("R8 flag not before edge", v, 8'h00);
        cyc(1);
        rd(2'd2, v); chk("R8 flag at once", v, 8'h01);
        wr(2'd2, 8'h00);
    endtask

    task automatic t_level();
        logic [7:0] v;
        wr(2'd1, 8'h05);
        chk("R9 lvl_sel", {5'd0, lvl_sel}, 8'h05);
        rd(2'd1, v); chk("R9 lvl read", v, 8'h05);
        rd(2'd0, v); chk("R9 restart status", v, 8'h80);
        cyc(N - 1);
        rd(2'd0, v); chk("R9 still settling", v, 8'h80);
        cyc(1);
        rd(2'd0, v); chk("R9 settled again", v, 8'h81);
        cyc(2);
        wr(2'd2, 8'h02);
    endtask

    task automatic t_stop();
        logic [7:0] v;
        @(negedge clk); stop_mode = 1'b1;
        @(negedge clk); stop_mode = 1'b0;
        chk("R3 stop off", {7'd0, ana_pwr}, 8'h00);
        rd(2'd0, v); chk("R3 status off", v, 8'h80);
        cyc(5);
        chk("R3 stays off", {7'd0, ana_pwr}, 8'h00);
        @(negedge clk);
        stop_mode = 1'b1; wr_en = 1'b1; addr = 2'd0; wdata = 8'h80;
        @(negedge clk);
        stop_mode = 1'b0; wr_en = 1'b0;
        chk("R3 stop wins", {7'd0, ana_pwr}, 8'h00);
        wr(2'd0, 8'h80);
        chk("R2 pwr again", {7'd0, ana_pwr}, 8'h01);
        cyc(N - 1);
        rd(2'd0, v); chk("R4 resettle", v, 8'h80);
        cyc(1);
        rd(2'd0, v); chk("R4 resettled", v, 8'h81);
    endtask

    initial begin
        cyc(3);
        rst_n = 1'b1;
        cyc(1);
        t_reset();
        t_power();
        t_sync();
        t_disable();
        t_level();
        t_stop();
        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            total++; bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule